// File: doc/BRIEF.md
# Periodic 64-bit Compare Timer

This block keeps a 64-bit up-counter that advances once every (divider + 1) clock cycles while it is running. A 64-bit threshold is matched against it. When the count reaches or passes the threshold, a compare event occurs. The event latches a sticky event flag and can send a one-cycle interrupt pulse.

In periodic mode, each event adds a 32-bit step to the threshold. This produces a steady stream of ticks with no further software writes. In one-shot mode, a threshold fires once and stays quiet until software writes it again.

All state is reached through a 32-bit word-addressed register port with single-cycle writes and combinational reads. The 64-bit quantities are split into low and high words. The two halves of the count are not captured together. Software detects a carry between the two reads by reading the high word again.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset, every register reads zero and `irq_pulse` is low.
- R2: While the run bit (control bit 0) is set, the count rises by one once every (divider + 1) cycles, where the divider is control bits 15:8. While the run bit is clear, the count holds.
- R3: The count is 64 bits wide and is read as a low word at offset 0x00 and a high word at offset 0x04. A carry out of the low word enters the high word.
- R4: Writes to the count words (0x00, 0x04) take effect only while the run bit is clear. While the run bit is set, they are ignored.
- R5: Writes to the threshold words (low at 0x10, high at 0x14) are ignored while the compare bit (control bit 1) is set.
- R6: A compare event occurs only when the run bit and the compare bit are both set and the count is greater than or equal to the threshold. The event sets the event flag (bit 0 of offset 0x0C).
- R7: Writing 1 to bit 0 of offset 0x0C clears the event flag. Writing 0 there leaves the flag unchanged.
- R8: `irq_pulse` is high for exactly the one cycle after a compare event, and only if the interrupt bit (control bit 2) is set.
- R9: With the periodic bit (control bit 3) set, each event adds the step register (offset 0x18) to the threshold, so events recur every step count values.
- R10: With the periodic bit clear, a threshold produces one event only. Writing a threshold word arms the next event again.
- R11: The control register at offset 0x08 keeps only bits 3:0 and 15:8. All its other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_pulse | output | 1 | One-cycle interrupt pulse per enabled event |

## Verification
The assertions assume that the bus makes at most one word-aligned access per cycle. They also assume that the periodic step is nonzero whenever periodic mode runs; with a zero step the threshold never moves and events would repeat every cycle. The stimulus always programs a nonzero step before it sets the periodic bit. It rewrites the threshold only after it has cleared the compare bit, except where it tests that such writes are dropped. Count words are loaded while the counter is stopped, apart from the single deliberate write made while it is running.

// File: rtl/tick_cmp_timer_pkg.sv
package tick_cmp_timer_pkg;
    localparam int DW        = 32;
    localparam int CW        = 2 * DW;
    localparam int PRESC_W   = 8;
    localparam int PRESC_LSB = 8;

    localparam logic [2:0] IDX_CNT_LO = 3'd0;
    localparam logic [2:0] IDX_CNT_HI = 3'd1;
    localparam logic [2:0] IDX_CTRL   = 3'd2;
    localparam logic [2:0] IDX_FLAG   = 3'd3;
    localparam logic [2:0] IDX_THR_LO = 3'd4;
    localparam logic [2:0] IDX_THR_HI = 3'd5;
    localparam logic [2:0] IDX_STEP   = 3'd6;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic               periodic;
        logic               irq_en;
        logic               cmp_en;
        logic               run;
    } ctrl_t;

    typedef struct packed {
        ctrl_t          ctrl;
        logic [CW-1:0]  thr;
        logic [DW-1:0]  step;
        logic           flag;
        logic           armed;
        logic           irq;
    } tmr_state_t;
endpackage

// File: rtl/tick_cmp_presc.sv
module tick_cmp_presc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] pc_d, pc_q;

    always_comb begin
        tick = en && (pc_q >= limit);
        pc_d = pc_q;
        if (!en)
            pc_d = '0;
        else if (tick)
            pc_d = '0;
        else
            pc_d = W'(pc_q + 1'b1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end
endmodule

// File: rtl/tick_cmp_count.sv
module tick_cmp_count #(
    parameter int DW = 32,
    localparam int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [DW-1:0] wdata,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ld_lo)
            cnt_d[DW-1:0] = wdata;
        else if (ld_hi)
            cnt_d[CW-1:DW] = wdata;
        else if (inc)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tick_cmp_match.sv
module tick_cmp_match #(
    parameter int CW = 64
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] thr,
    input  logic          run,
    input  logic          cmp_en,
    input  logic          armed,
    output logic          hit
);
    always_comb hit = run && cmp_en && armed && (cnt >= thr);
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
    import tick_cmp_timer_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_pulse
);
    tmr_state_t st_d, st_q;

    logic [2:0]    idx;
    logic          aligned, wr_en;
    logic          tick_w, hit_w, cnt_ld_lo, cnt_ld_hi;
    logic [CW-1:0] cnt_w;

    assign aligned   = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:5] == '0);
    assign idx       = bus_addr[4:2];
    assign wr_en     = bus_sel && bus_wr && aligned;
    assign cnt_ld_lo = wr_en && (idx == IDX_CNT_LO) && !st_q.ctrl.run;
    assign cnt_ld_hi = wr_en && (idx == IDX_CNT_HI) && !st_q.ctrl.run;

    tick_cmp_presc #(.W(PRESC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (st_q.ctrl.run),
        .limit (st_q.ctrl.presc),
        .tick  (tick_w)
    );

    tick_cmp_count #(.DW(DW)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick_w),
        .ld_lo (cnt_ld_lo),
        .ld_hi (cnt_ld_hi),
        .wdata (bus_wdata),
        .cnt   (cnt_w)
    );

    tick_cmp_match #(.CW(CW)) u_match (
        .cnt    (cnt_w),
        .thr    (st_q.thr),
        .run    (st_q.ctrl.run),
        .cmp_en (st_q.ctrl.cmp_en),
        .armed  (st_q.armed),
        .hit    (hit_w)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (idx)
                IDX_CTRL: begin
                    st_d.ctrl.run      = bus_wdata[0];
                    st_d.ctrl.cmp_en   = bus_wdata[1];
                    st_d.ctrl.irq_en   = bus_wdata[2];
                    st_d.ctrl.periodic = bus_wdata[3];
                    st_d.ctrl.presc    = bus_wdata[PRESC_LSB +: PRESC_W];
                end
                IDX_FLAG: if (bus_wdata[0]) st_d.flag = 1'b0;
                IDX_THR_LO: if (!st_q.ctrl.cmp_en) begin
                    st_d.thr[DW-1:0] = bus_wdata;
                    st_d.armed       = 1'b1;
                end
                IDX_THR_HI: if (!st_q.ctrl.cmp_en) begin
                    st_d.thr[CW-1:DW] = bus_wdata;
                    st_d.armed        = 1'b1;
                end
                IDX_STEP: st_d.step = bus_wdata;
                default: ;
            endcase
        end
        if (hit_w) begin
            st_d.flag = 1'b1;
            if (st_q.ctrl.periodic)
                st_d.thr = st_q.thr + CW'(st_q.step);
            else
                st_d.armed = 1'b0;
        end
        st_d.irq = hit_w && st_q.ctrl.irq_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (idx)
                IDX_CNT_LO: bus_rdata = cnt_w[DW-1:0];
                IDX_CNT_HI: bus_rdata = cnt_w[CW-1:DW];
                IDX_CTRL: begin
                    bus_rdata[0] = st_q.ctrl.run;
                    bus_rdata[1] = st_q.ctrl.cmp_en;
                    bus_rdata[2] = st_q.ctrl.irq_en;
                    bus_rdata[3] = st_q.ctrl.periodic;
                    bus_rdata[PRESC_LSB +: PRESC_W] = st_q.ctrl.presc;
                end
                IDX_FLAG:   bus_rdata[0] = st_q.flag;
                IDX_THR_LO: bus_rdata = st_q.thr[DW-1:0];
                IDX_THR_HI: bus_rdata = st_q.thr[CW-1:DW];
                IDX_STEP:   bus_rdata = st_q.step;
                default: ;
            endcase
        end
    end

    assign irq_pulse = st_q.irq;
endmodule

// File: rtl/tick_cmp_timer_chk.sv
module tick_cmp_timer_chk
    import tick_cmp_timer_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [4:0]    bus_addr,
    input logic          irq_pulse,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] thr,
    input logic [DW-1:0] step,
    input logic          run,
    input logic          cmp_en,
    input logic          irq_en,
    input logic          periodic,
    input logic          hit,
    input logic          flag
);
    logic cnt_bus_wr;
    assign cnt_bus_wr = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00) &&
                        ((bus_addr[4:2] == IDX_CNT_LO) || (bus_addr[4:2] == IDX_CNT_HI));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_bus_wr |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 64'd1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_bus_wr) |=> $stable(cnt));

    // R4
    cnt_wr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_bus_wr) |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 64'd1));

    // R5
    thr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && !hit) |=> $stable(thr));

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(hit && irq_en));

    // R9
    periodic_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && periodic) |=> (thr == $past(thr) + {32'd0, $past(step)}));

    // R10
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !periodic) |=> !hit);
endmodule

bind tick_cmp_timer tick_cmp_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .irq_pulse (irq_pulse),
    .cnt       (cnt_w),
    .thr       (st_q.thr),
    .step      (st_q.step),
    .run       (st_q.ctrl.run),
    .cmp_en    (st_q.ctrl.cmp_en),
    .irq_en    (st_q.ctrl.irq_en),
    .periodic  (st_q.ctrl.periodic),
    .hit       (hit_w),
    .flag      (st_q.flag)
);

// File: tb/tick_cmp_timer_bench.sv
module tick_cmp_timer_bench;
    localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08, A_FLG = 5'h0C,
                           A_TLO = 5'h10, A_THI = 5'h14, A_STP = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        bit          is_irq;
        string       req;
    } item_t;
    item_t sb_q[$];
    event  mon_ev;

    always #4 clk = ~clk;

    tick_cmp_timer u_tick_cmp_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pulse (irq_pulse)
    );

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'd0, irq_pulse} : bus_rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0;
        end
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
        item_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        it.exp = exp; it.is_irq = 1'b0; it.req = req;
        sb_q.push_back(it);
        -> mon_ev;
        #1;
    endtask

    task automatic irq_is(input logic e, input string req);
        item_t it;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
        it.exp = {31'd0, e}; it.is_irq = 1'b1; it.req = req;
        sb_q.push_back(it);
        -> mon_ev;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_CLO, 0, "R1"); rd(A_CHI, 0, "R1"); rd(A_CTL, 0, "R1"); rd(A_FLG, 0, "R1");
        rd(A_TLO, 0, "R1"); rd(A_THI, 0, "R1"); rd(A_STP, 0, "R1");
        irq_is(1'b0, "R1");

        // R11: control layout keeps bits 3:0 and 15:8 only
        wr(A_CTL, 32'hABCD_12F8);
        rd(A_CTL, 32'h0000_1208, "R11");
        wr(A_CTL, 0);

        // R2: divider 0, counter runs for 10 cycles
        wr(A_CTL, 32'h1); idle(9); wr(A_CTL, 0);
        rd(A_CLO, 10, "R2"); rd(A_CHI, 0, "R2");

        // R2: divider 3, 20 cycles give 5 steps
        wr(A_CLO, 0);
        wr(A_CTL, 32'h301); idle(19); wr(A_CTL, 0);
        rd(A_CLO, 5, "R2");
        idle(5);
        rd(A_CLO, 5, "R2 hold");

        // R3: carry from low to high word
        wr(A_CLO, 32'hFFFF_FFFE); wr(A_CHI, 0);
        wr(A_CTL, 32'h1); idle(2); wr(A_CTL, 0);
        rd(A_CLO, 1, "R3"); rd(A_CHI, 1, "R3");

        // R4: count write while running is ignored
        wr(A_CTL, 32'h1); wr(A_CLO, 32'h1234); wr(A_CTL, 0);
        rd(A_CLO, 3, "R4"); rd(A_CHI, 1, "R4");

        // R6/R8: one-shot event at count 20 with interrupt enabled
        wr(A_CLO, 0); wr(A_CHI, 0); wr(A_TLO, 20); wr(A_THI, 0);
        wr(A_CTL, 32'h7); idle(20);
        irq_is(1'b0, "R8 before");
        irq_is(1'b1, "R8 pulse");
        irq_is(1'b0, "R8 after");
        rd(A_FLG, 1, "R6");

        // R7: write 0 keeps flag, write 1 clears
        wr(A_FLG, 0); rd(A_FLG, 1, "R7 keep");
        wr(A_FLG, 1); idle(10);
        rd(A_FLG, 0, "R7 clear / R10 no refire");
        irq_is(1'b0, "R10");

        // R5: threshold write dropped while compare enabled
        wr(A_TLO, 5); rd(A_TLO, 20, "R5");

        // R10: rewriting threshold re-arms
        wr(A_CTL, 32'h5); wr(A_TLO, 0); wr(A_CTL, 32'h7);
        irq_is(1'b0, "R10 rearm");
        irq_is(1'b1, "R10 rearm");
        rd(A_FLG, 1, "R10 rearm");

        // R8: no pulse without interrupt enable
        wr(A_CTL, 0); wr(A_FLG, 1); wr(A_CLO, 0); wr(A_TLO, 3);
        wr(A_CTL, 32'h3);
        for (int i = 0; i < 8; i++) irq_is(1'b0, "R8 masked");
        rd(A_FLG, 1, "R8 masked flag");

        // R6: no event with compare disabled
        wr(A_CTL, 0); wr(A_FLG, 1); wr(A_CLO, 0); wr(A_TLO, 2);
        wr(A_CTL, 32'h5); idle(10);
        rd(A_FLG, 0, "R6 cmp off");

        // R9: periodic events every 8 counts from 10
        wr(A_CTL, 0); wr(A_FLG, 1); wr(A_CLO, 0); wr(A_CHI, 0);
        wr(A_TLO, 10); wr(A_THI, 0); wr(A_STP, 8);
        rd(A_STP, 8, "R9 step");
        wr(A_CTL, 32'hF);
        for (int i = 1; i <= 30; i++)
            irq_is((i == 12) || (i == 20) || (i == 28), "R9 periodic");
        wr(A_CTL, 0);
        rd(A_TLO, 34, "R9 threshold");
        rd(A_CLO, 31, "R9 count");
        rd(A_FLG, 1, "R9 flag");

        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule